// File: doc/BRIEF.md
# Register-Access Packet Error Check Controller

This block sits between a byte-level I2C target front end and a register file. It adds CRC-8 packet error checking to single-byte register writes and reads. The front end reports START (including repeated START) and STOP events, each received byte, and each request for a byte to transmit. The block tracks the byte position in the transaction itself. It answers every received byte with an ACK/NACK decision. It drives a register write strobe with address and data, supplies the byte to transmit (register data or PEC), and raises an active-low interrupt.

A write transaction is START, address byte, command byte, data byte, an optional PEC byte, then STOP. The register write is held back until the PEC question is settled. That happens either at the PEC byte or at the STOP. Three configuration inputs set the policy: enable checking, demand a PEC, and raise an interrupt on a PEC fault. Together they decide whether a missing or wrong PEC is ACKed, NACKed, executed or discarded. A read transaction is START, address, command, repeated START, read address, then one or two transmitted bytes. The CRC runs on across the repeated START, so the PEC returned after the data covers all four bytes.

Top module: `pec_reg_gate`

## Requirements
- R1: The CRC is CRC-8 with polynomial 0x07, reset to 0x00 at each new transaction, processed MSB first with no final XOR. It covers the address, command and data bytes. When `cfg_en_i`=1 and the byte after the data byte equals that CRC, the byte gets `ack_o`=1 and `wr_en_o` pulses with `wr_addr_o`=command and `wr_data_o`=data in the same cycle as that ACK.
- R2: When `cfg_en_i`=1 and the PEC byte differs from the CRC, that byte gets `ack_o`=0 and no write happens.
- R3: With `cfg_en_i`=0, the write is committed at STOP. `wr_en_o` pulses in the cycle after the STOP pulse. No interrupt is raised.
- R4: With `cfg_en_i`=1 and `cfg_req_i`=0, a write that ends at STOP without a PEC byte is committed at the STOP.
- R5: With `cfg_en_i`=1 and `cfg_req_i`=1, a write missing its PEC does not execute, even though its data byte was ACKed. With `cfg_irq_i`=0, no PEC fault raises an interrupt.
- R6: `irq_no` goes low only when `cfg_en_i`, `cfg_req_i` and `cfg_irq_i` are all 1 and a write ends with a wrong or missing PEC. It stays low until `irq_clr_i` is pulsed, and then returns high.
- R7: A pending write never reaches the register file before its PEC byte or its STOP.
- R8: On a read, the first transmitted byte is `rd_data_i` at `rd_addr_o` = command byte. With `cfg_en_i`=1, the second byte is the CRC over the write address, command, read address and data bytes. Each `tx_req_i` pulse is answered by `tx_valid_o` in the next cycle.
- R9: With `cfg_en_i`=0, a second transmit request in a read returns the fill value 0xFF, not a PEC.
- R10: A START that arrives while a write is pending discards the write and restarts the CRC at 0x00.
- R11: After reset, `irq_no`=1 and `wr_en_o`, `ack_valid_o` and `tx_valid_o` are 0.
- R12: Address, command and data bytes are always ACKed. Each received byte is answered by `ack_valid_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Enable packet error checking |
| cfg_req_i | input | 1 | Treat a missing PEC on writes as a fault |
| cfg_irq_i | input | 1 | Raise the interrupt on write PEC faults |
| start_i | input | 1 | START or repeated START pulse |
| stop_i | input | 1 | STOP pulse |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| ack_valid_o | output | 1 | ACK decision valid |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| tx_req_i | input | 1 | Front end requests a byte to transmit |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_byte_o | output | 8 | Byte to transmit |
| rd_addr_o | output | 8 | Register read address (command byte) |
| rd_data_i | input | 8 | Register read data |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | 8 | Register write address |
| wr_data_o | output | 8 | Register write data |
| irq_clr_i | input | 1 | Clears the interrupt |
| irq_no | output | 1 | Interrupt, active low |

## Verification
Writes are driven with a correct PEC, a corrupted PEC and no PEC under each configuration combination. This separates commit-on-PEC, NACK, commit-at-STOP, silent discard and discard with interrupt. The bench holds the bus idle between the data byte and the STOP, which exposes any early write. Reads are run with checking on and off, so the PEC covering the repeated-START address is distinguished from the fill byte. A restart in the middle of a write is tried twice. Once it is followed directly by a STOP, which shows that the pending write was dropped. Once it is followed by a fresh write whose PEC matches only a CRC restarted from zero.

// File: rtl/pec_pkg.sv
package pec_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_ADDR, PH_CMD, PH_DATA, PH_PEC,
    PH_DONE, PH_RADDR, PH_RDATA, PH_RPEC
  } phase_e;
endpackage

// File: rtl/pec_crc_step.sv
module pec_crc_step #(
  parameter int unsigned    W    = 8,
  parameter logic [W-1:0]   POLY = 8'h07
) (
  input  logic [W-1:0] crc_i,
  input  logic [W-1:0] byte_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] st [0:W];

  assign st[0] = crc_i ^ byte_i;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign st[i+1] = st[i][W-1] ? ({st[i][W-2:0], 1'b0} ^ POLY)
                                : {st[i][W-2:0], 1'b0};
  end
  assign crc_o = st[W];
endmodule

// File: rtl/pec_seq_fsm.sv
module pec_seq_fsm
  import pec_pkg::*;
#(
  parameter int unsigned  DW   = 8,
  parameter logic [DW-1:0] POLY = 8'h07,
  parameter logic [DW-1:0] FILL = 8'hFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_en_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_byte_i,
  input  logic          tx_req_i,
  input  logic [DW-1:0] rd_data_i,
  output phase_e        phase_o,
  output logic          pend_o,
  output logic [DW-1:0] crc_o,
  output logic [DW-1:0] cmd_o,
  output logic [DW-1:0] data_o,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_byte_o
);
  phase_e        phase_q;
  logic          pend_q, tx_valid_q;
  logic [DW-1:0] crc_q, cmd_q, data_q, tx_byte_q;
  logic [DW-1:0] upd_byte, crc_nx;

  // transmitted data byte also enters the CRC
  assign upd_byte = (tx_req_i && phase_q == PH_RDATA) ? rd_data_i : rx_byte_i;

  pec_crc_step #(.W(DW), .POLY(POLY)) u_step (
    .crc_i (crc_q),
    .byte_i(upd_byte),
    .crc_o (crc_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      pend_q     <= 1'b0;
      crc_q      <= '0;
      cmd_q      <= '0;
      data_q     <= '0;
      tx_valid_q <= 1'b0;
      tx_byte_q  <= '0;
    end else begin
      tx_valid_q <= 1'b0;
      if (start_i) begin
        pend_q <= 1'b0;
        if (phase_q == PH_DATA) begin
          phase_q <= PH_RADDR;           // repeated start of a read: keep CRC
        end else begin
          phase_q <= PH_ADDR;
          crc_q   <= '0;
        end
      end else if (stop_i) begin
        phase_q <= PH_IDLE;
        pend_q  <= 1'b0;
      end else if (rx_valid_i) begin
        unique case (phase_q)
          PH_ADDR: begin
            crc_q   <= crc_nx;
            phase_q <= PH_CMD;
          end
          PH_CMD: begin
            cmd_q   <= rx_byte_i;
            crc_q   <= crc_nx;
            phase_q <= PH_DATA;
          end
          PH_DATA: begin
            data_q  <= rx_byte_i;
            crc_q   <= crc_nx;
            pend_q  <= 1'b1;
            phase_q <= PH_PEC;
          end
          PH_PEC: begin
            if (cfg_en_i) begin
              pend_q  <= 1'b0;
              phase_q <= PH_DONE;
            end
          end
          PH_RADDR: begin
            crc_q   <= crc_nx;
            phase_q <= PH_RDATA;
          end
          default: ;
        endcase
      end else if (tx_req_i) begin
        tx_valid_q <= 1'b1;
        unique case (phase_q)
          PH_RDATA: begin
            tx_byte_q <= rd_data_i;
            crc_q     <= crc_nx;
            phase_q   <= PH_RPEC;
          end
          PH_RPEC: begin
            tx_byte_q <= cfg_en_i ? crc_q : FILL;
            phase_q   <= PH_DONE;
          end
          default: tx_byte_q <= FILL;
        endcase
      end
    end
  end

  assign phase_o    = phase_q;
  assign pend_o     = pend_q;
  assign crc_o      = crc_q;
  assign cmd_o      = cmd_q;
  assign data_o     = data_q;
  assign tx_valid_o = tx_valid_q;
  assign tx_byte_o  = tx_byte_q;
endmodule

// File: rtl/pec_policy.sv
module pec_policy
  import pec_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          cfg_en_i,
  input  logic          cfg_req_i,
  input  logic          cfg_irq_i,
  input  logic          rx_valid_i,
  input  logic          stop_i,
  input  logic [DW-1:0] rx_byte_i,
  input  phase_e        phase_i,
  input  logic          pend_i,
  input  logic [DW-1:0] crc_i,
  output logic          commit_o,
  output logic          ack_o,
  output logic          irq_set_o
);
  logic pec_rx, pec_ok, end_no_pec, fault;

  always_comb begin
    pec_rx     = rx_valid_i && cfg_en_i && (phase_i == PH_PEC);
    pec_ok     = (rx_byte_i == crc_i);
    end_no_pec = stop_i && pend_i;
    commit_o   = (pec_rx && pec_ok) || (end_no_pec && !(cfg_en_i && cfg_req_i));
    fault      = (pec_rx && !pec_ok) || (end_no_pec && cfg_en_i && cfg_req_i);
    ack_o      = !(pec_rx && !pec_ok);
    irq_set_o  = fault && cfg_en_i && cfg_req_i && cfg_irq_i;
  end
endmodule

// File: rtl/pec_reg_gate.sv
module pec_reg_gate
  import pec_pkg::*;
#(
  parameter int unsigned   DW   = 8,
  parameter logic [DW-1:0] POLY = 8'h07,
  parameter logic [DW-1:0] FILL = 8'hFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_en_i,
  input  logic          cfg_req_i,
  input  logic          cfg_irq_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_byte_i,
  output logic          ack_valid_o,
  output logic          ack_o,
  input  logic          tx_req_i,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_byte_o,
  output logic [DW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_en_o,
  output logic [DW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  input  logic          irq_clr_i,
  output logic          irq_no
);
  logic          rx_eff, stop_eff, tx_eff;
  phase_e        phase;
  logic          pend, commit, ack_bit, irq_set;
  logic [DW-1:0] crc, cmd, data;
  logic          ack_valid_q, ack_q, wr_en_q, irq_q;
  logic [DW-1:0] wr_addr_q, wr_data_q;

  // START outranks STOP, which outranks byte traffic
  assign stop_eff = stop_i & ~start_i;
  assign rx_eff   = rx_valid_i & ~start_i & ~stop_i;
  assign tx_eff   = tx_req_i & ~rx_valid_i & ~start_i & ~stop_i;

  pec_seq_fsm #(.DW(DW), .POLY(POLY), .FILL(FILL)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_en_i  (cfg_en_i),
    .start_i   (start_i),
    .stop_i    (stop_eff),
    .rx_valid_i(rx_eff),
    .rx_byte_i (rx_byte_i),
    .tx_req_i  (tx_eff),
    .rd_data_i (rd_data_i),
    .phase_o   (phase),
    .pend_o    (pend),
    .crc_o     (crc),
    .cmd_o     (cmd),
    .data_o    (data),
    .tx_valid_o(tx_valid_o),
    .tx_byte_o (tx_byte_o)
  );

  pec_policy #(.DW(DW)) u_pol (
    .cfg_en_i  (cfg_en_i),
    .cfg_req_i (cfg_req_i),
    .cfg_irq_i (cfg_irq_i),
    .rx_valid_i(rx_eff),
    .stop_i    (stop_eff),
    .rx_byte_i (rx_byte_i),
    .phase_i   (phase),
    .pend_i    (pend),
    .crc_i     (crc),
    .commit_o  (commit),
    .ack_o     (ack_bit),
    .irq_set_o (irq_set)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_valid_q <= 1'b0;
      ack_q       <= 1'b0;
      wr_en_q     <= 1'b0;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
      irq_q       <= 1'b0;
    end else begin
      ack_valid_q <= rx_eff;
      ack_q       <= ack_bit;
      wr_en_q     <= commit;
      if (commit) begin
        wr_addr_q <= cmd;
        wr_data_q <= data;
      end
      if (irq_set)        irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign ack_valid_o = ack_valid_q;
  assign ack_o       = ack_q;
  assign wr_en_o     = wr_en_q;
  assign wr_addr_o   = wr_addr_q;
  assign wr_data_o   = wr_data_q;
  assign rd_addr_o   = cmd;
  assign irq_no      = ~irq_q;
endmodule

// File: rtl/pec_reg_gate_chk.sv
module pec_reg_gate_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_en_i,
  input logic cfg_req_i,
  input logic cfg_irq_i,
  input logic stop_i,
  input logic rx_valid_i,
  input logic tx_req_i,
  input logic ack_valid_o,
  input logic ack_o,
  input logic tx_valid_o,
  input logic wr_en_o,
  input logic irq_clr_i,
  input logic irq_no
);
  assert_nack_blocks_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_valid_o && !ack_o) |-> !wr_en_o);

  assert_irq_needs_cfg_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> $past(cfg_en_i && cfg_req_i && cfg_irq_i));

  assert_irq_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && !irq_clr_i) |=> !irq_no);

  assert_write_after_event_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(rx_valid_i || stop_i));

  assert_tx_answer_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(tx_req_i));

  assert_ack_answer_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> $past(rx_valid_i));
endmodule

bind pec_reg_gate pec_reg_gate_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_en_i   (cfg_en_i),
  .cfg_req_i  (cfg_req_i),
  .cfg_irq_i  (cfg_irq_i),
  .stop_i     (stop_i),
  .rx_valid_i (rx_valid_i),
  .tx_req_i   (tx_req_i),
  .ack_valid_o(ack_valid_o),
  .ack_o      (ack_o),
  .tx_valid_o (tx_valid_o),
  .wr_en_o    (wr_en_o),
  .irq_clr_i  (irq_clr_i),
  .irq_no     (irq_no)
);

// File: tb/sim_pec_reg_gate.sv
module sim_pec_reg_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 0, cfg_req = 0, cfg_irq = 0;
  logic       start = 0, stop = 0, rx_valid = 0, tx_req = 0, irq_clr = 0;
  logic [7:0] rx_byte = '0;
  logic       ack_valid, ack, tx_valid, wr_en, irq_n;
  logic [7:0] tx_byte, rd_addr, rd_data, wr_addr, wr_data;

  always #5 clk = ~clk;

  assign rd_data = rd_addr ^ 8'h5A;

  pec_reg_gate u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_req_i(cfg_req),
    .cfg_irq_i(cfg_irq), .start_i(start), .stop_i(stop),
    .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .ack_valid_o(ack_valid), .ack_o(ack), .tx_req_i(tx_req),
    .tx_valid_o(tx_valid), .tx_byte_o(tx_byte), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .irq_clr_i(irq_clr), .irq_no(irq_n)
  );

  localparam int K_ACK = 0, K_WR = 1, K_TX = 2, K_IRQ = 3;
  int    q_kind[$];
  int    q_val[$];
  string q_req[$];
  int    n_chk = 0, n_fail = 0, wr_seen = 0;
  bit    mon_on = 0;
  logic  irq_prev = 1'b1;

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r = c ^ b;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  function automatic void check(bit ok, string req, int act, int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endfunction

  function automatic void expect_ev(int k, int v, string req);
    q_kind.push_back(k);
    q_val.push_back(v);
    q_req.push_back(req);
  endfunction

  function automatic void pop_cmp(int k, int v);
    if (q_kind.size() == 0) begin
      check(0, "R7 unexpected event", k * 65536 + v, -1);
    end else begin
      int    ek = q_kind.pop_front();
      int    ev = q_val.pop_front();
      string er = q_req.pop_front();
      check(ek == k && ev == v, er, k * 65536 + v, ek * 65536 + ev);
    end
  endfunction

  // monitor: outputs sampled on the falling edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (ack_valid) pop_cmp(K_ACK, int'(ack));
      if (wr_en) begin
        wr_seen++;
        pop_cmp(K_WR, int'({wr_addr, wr_data}));
      end
      if (tx_valid) pop_cmp(K_TX, int'(tx_byte));
      if (irq_prev && !irq_n) pop_cmp(K_IRQ, 0);
      irq_prev = irq_n;
    end
  end

  task automatic ev_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask
  task automatic ev_stop();
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
  endtask
  task automatic ev_rx(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask
  task automatic ev_tx();
    @(negedge clk); tx_req = 1;
    @(negedge clk); tx_req = 0;
  endtask
  task automatic set_cfg(input logic e, input logic r, input logic i);
    @(negedge clk); cfg_en = e; cfg_req = r; cfg_irq = i;
  endtask
  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
  endtask

  // START, address, command, data; returns the CRC over those three bytes
  task automatic wr_head(input logic [7:0] cmd, input logic [7:0] dat, output logic [7:0] c);
    expect_ev(K_ACK, 1, "R12 addr");
    expect_ev(K_ACK, 1, "R12 cmd");
    expect_ev(K_ACK, 1, "R12 data");
    ev_start();
    ev_rx(8'h90);
    ev_rx(cmd);
    ev_rx(dat);
    c = crc8(crc8(crc8(8'h00, 8'h90), cmd), dat);
  endtask

  initial begin
    logic [7:0] c;
    int w0;
    repeat (3) @(negedge clk);
    check(irq_n == 1'b1, "R11 irq_no in reset", irq_n, 1);
    check(wr_en == 1'b0, "R11 wr_en in reset", wr_en, 0);
    check(ack_valid == 1'b0 && tx_valid == 1'b0, "R11 valids in reset", ack_valid, 0);
    rst_n = 1;
    mon_on = 1;

    // R1: correct PEC commits at the PEC byte
    set_cfg(1, 0, 0);
    wr_head(8'h12, 8'h34, c);
    expect_ev(K_ACK, 1, "R1 pec ack");
    expect_ev(K_WR, 16'h1234, "R1 write on good pec");
    ev_rx(c);
    ev_stop();

    // R2: wrong PEC is NACKed and dropped
    wr_head(8'h22, 8'hA5, c);
    expect_ev(K_ACK, 0, "R2 nack on bad pec");
    ev_rx(c ^ 8'h01);
    ev_stop();

    // R3: checking off, commit at STOP
    set_cfg(0, 1, 1);
    wr_head(8'h33, 8'h0F, c);
    expect_ev(K_WR, 16'h330F, "R3 write at stop");
    ev_stop();

    // R4 + R7: optional PEC missing, write held until STOP
    set_cfg(1, 0, 1);
    wr_head(8'h44, 8'hC3, c);
    w0 = wr_seen;
    repeat (6) @(negedge clk);
    check(wr_seen == w0, "R7 write held before stop", wr_seen, w0);
    expect_ev(K_WR, 16'h44C3, "R4 write at stop");
    ev_stop();

    // R5: PEC demanded, missing, no interrupt enable
    set_cfg(1, 1, 0);
    wr_head(8'h55, 8'h11, c);
    ev_stop();
    repeat (2) @(negedge clk);
    check(irq_n == 1'b1, "R5 no irq without enable", irq_n, 1);

    // R5: wrong PEC with interrupt disabled
    wr_head(8'h56, 8'h12, c);
    expect_ev(K_ACK, 0, "R5 nack bad pec no irq");
    ev_rx(c ^ 8'h80);
    ev_stop();
    check(irq_n == 1'b1, "R5 irq stays high", irq_n, 1);

    // R6: missing PEC with interrupt enabled
    set_cfg(1, 1, 1);
    wr_head(8'h66, 8'h22, c);
    expect_ev(K_IRQ, 0, "R6 irq on missing pec");
    ev_stop();
    repeat (4) @(negedge clk);
    check(irq_n == 1'b0, "R6 irq held", irq_n, 0);
    pulse_clr();
    check(irq_n == 1'b1, "R6 irq cleared", irq_n, 1);

    // R6: wrong PEC with interrupt enabled
    wr_head(8'h67, 8'h23, c);
    expect_ev(K_ACK, 0, "R6 nack");
    expect_ev(K_IRQ, 0, "R6 irq on bad pec");
    ev_rx(c ^ 8'hFF);
    ev_stop();
    pulse_clr();
    check(irq_n == 1'b1, "R6 irq cleared again", irq_n, 1);

    // R8: read with PEC
    set_cfg(1, 0, 0);
    expect_ev(K_ACK, 1, "R12 raddr w");
    expect_ev(K_ACK, 1, "R12 rcmd");
    ev_start();
    ev_rx(8'h90);
    ev_rx(8'h21);
    ev_start();
    expect_ev(K_ACK, 1, "R12 raddr r");
    ev_rx(8'h91);
    expect_ev(K_TX, 8'h21 ^ 8'h5A, "R8 read data");
    ev_tx();
    c = crc8(crc8(crc8(crc8(8'h00, 8'h90), 8'h21), 8'h91), 8'h21 ^ 8'h5A);
    expect_ev(K_TX, c, "R8 read pec");
    ev_tx();
    ev_stop();

    // R9: read without PEC
    set_cfg(0, 0, 0);
    expect_ev(K_ACK, 1, "R12 addr");
    expect_ev(K_ACK, 1, "R12 cmd");
    ev_start();
    ev_rx(8'h90);
    ev_rx(8'h7E);
    ev_start();
    expect_ev(K_ACK, 1, "R12 addr r");
    ev_rx(8'h91);
    expect_ev(K_TX, 8'h7E ^ 8'h5A, "R9 read data");
    ev_tx();
    expect_ev(K_TX, 8'hFF, "R9 fill, no pec");
    ev_tx();
    ev_stop();

    // R10: restart drops the pending write
    wr_head(8'h12, 8'h34, c);
    ev_start();
    ev_stop();
    repeat (2) @(negedge clk);

    // R10: restart resets the CRC
    set_cfg(1, 0, 0);
    wr_head(8'h12, 8'h34, c);
    expect_ev(K_ACK, 1, "R12 addr2");
    expect_ev(K_ACK, 1, "R12 cmd2");
    expect_ev(K_ACK, 1, "R12 data2");
    ev_start();
    ev_rx(8'h90);
    ev_rx(8'h12);
    ev_rx(8'h56);
    c = crc8(crc8(crc8(8'h00, 8'h90), 8'h12), 8'h56);
    expect_ev(K_ACK, 1, "R10 pec after restart");
    expect_ev(K_WR, 16'h1256, "R10 write after restart");
    ev_rx(c);
    ev_stop();

    repeat (4) @(negedge clk);
    check(q_kind.size() == 0, "R1 all expected events seen", q_kind.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule